// File: doc/BRIEF.md
# Byte/Word Selectable Memory Read Port

This block is the read-side bus front end of a memory that holds 16-bit words and may be read either a whole word at a time or one byte at a time. A static organization input picks the bus width. With a 16-bit bus the topmost data pin is an ordinary data bit. With an 8-bit bus that same pin turns into the lowest address bit: it chooses which byte of the addressed word appears on the low eight data pins. The other upper pins are released in that mode.

Chip select and output enable, both active low, decide whether anything is driven. Every data pin comes with its own output-enable bit, active high, so the pad ring can build the tri-state buffers. All inputs are sampled on the rising clock edge and the pins reflect them one cycle later. A control state machine has four states: S_OFF (chip deselected), S_MUTE (selected, outputs off), S_WORD (16-bit drive) and S_BYTE (8-bit drive). Its transitions are T_DESELECT (chip select high, to S_OFF), T_MUTE (selected with output enable high, to S_MUTE), T_WORD (selected, reading, 16-bit organization, to S_WORD) and T_BYTE (selected, reading, 8-bit organization, to S_BYTE). Any state can take any of these transitions in any cycle. The stored contents come from a fixed computed pattern and reads never alter them.

Top module: `bwrp_read_port`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output-enable bit is 0 and every data output is 0.
- R2: The word stored at address A is `{A[7:0], A[15:8]} ^ 16'h3CA5`. Bits 15..8 are the high byte and bits 7..0 are the low byte.
- R3: With word_mode_i = 1 and ce_n_i = oe_n_i = 0 at a clock edge, the cycle after that edge shows the word at addr_i on dq_o[15:0], and dq_oe_o = 16'hFFFF.
- R4: With word_mode_i = 0, ce_n_i = oe_n_i = 0 and dq15_in_i = 0 at a clock edge, the next cycle shows the low byte of the word at addr_i on dq_o[7:0], with dq_o[15:8] = 0 and dq_oe_o = 16'h00FF.
- R5: With word_mode_i = 0, ce_n_i = oe_n_i = 0 and dq15_in_i = 1 at a clock edge, the next cycle shows the high byte of the word at addr_i on dq_o[7:0], with dq_o[15:8] = 0 and dq_oe_o = 16'h00FF.
- R6: In 8-bit mode, output-enable bits 15..8 are 0 one cycle later. This includes bit 15, the pin then used as an address input.
- R7: If ce_n_i = 1 at an edge, dq_oe_o = 0 and dq_o = 0 in the next cycle, whatever the other inputs are.
- R8: If ce_n_i = 0 and oe_n_i = 1 at an edge, dq_oe_o = 0 and dq_o = 0 in the next cycle.
- R9: A change of word_mode_i between back-to-back reads changes the lane layout from the next cycle on. Reads of the same address before and after the change return the same stored contents.
- R10: A data output bit is never 1 while its output-enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Word address |
| ce_n_i | input | 1 | Chip select, active low |
| oe_n_i | input | 1 | Output enable, active low |
| word_mode_i | input | 1 | Organization select: 1 = 16-bit bus, 0 = 8-bit bus |
| dq15_in_i | input | 1 | Input side of the top data pin; in 8-bit mode it is the byte-select address bit |
| dq_o | output | 16 | Data driven onto the data pins |
| dq_oe_o | output | 16 | Per-pin output enable, 1 = drive |

## Verification
Every result of this block is due exactly one clock cycle after the edge that sampled its inputs. This holds for word data, the selected byte, the release of the upper lanes and the muting from chip select or output enable. The driver sets the inputs just after a falling edge and pushes the expected pins into a queue. The monitor pops one item shortly after the next rising edge, once the registered outputs have settled. In this way every comparison lands in the single cycle where that result is due. Mode switches and byte-select flips are driven on back-to-back cycles, so a result that is late or early by one cycle shows up as a mismatch.

// File: rtl/bwrp_pkg.sv
package bwrp_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_MUTE = 2'd1,
        S_WORD = 2'd2,
        S_BYTE = 2'd3
    } bwrp_state_e;

    localparam logic [15:0] BWRP_KEY = 16'h3CA5;

endpackage

// File: rtl/bwrp_pattern_rom.sv
module bwrp_pattern_rom #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    import bwrp_pkg::*;

    localparam int NLANE  = DATA_W / 8;
    localparam int ABYTES = ADDR_W / 8;

    // Each word lane takes an address byte in reversed lane order, then a fixed key.
    for (genvar b = 0; b < NLANE; b++) begin : g_lane
        localparam int SRC = (NLANE - 1 - b) % ABYTES;
        assign word[b*8 +: 8] = addr[SRC*8 +: 8] ^ BWRP_KEY[(b % 2)*8 +: 8];
    end

endmodule

// File: rtl/bwrp_lane_mux.sv
module bwrp_lane_mux #(
    parameter int DATA_W = 16
) (
    input  logic              word_mode,
    input  logic              hi_sel,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] lanes
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        if (word_mode) begin
            lanes = word;
        end else begin
            lanes = '0;
            lanes[7:0] = hi_sel ? word[HALF +: 8] : word[7:0];
        end
    end

endmodule

// File: rtl/bwrp_ctrl_fsm.sv
module bwrp_ctrl_fsm (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce_n,
    input  logic                  oe_n,
    input  logic                  word_mode,
    output bwrp_pkg::bwrp_state_e state
);
    import bwrp_pkg::*;

    bwrp_state_e state_q, state_d;

    // next-state: T_DESELECT, T_MUTE, T_WORD, T_BYTE reachable from every state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF, S_MUTE, S_WORD, S_BYTE: begin
                if (ce_n)           state_d = S_OFF;   // T_DESELECT
                else if (oe_n)      state_d = S_MUTE;  // T_MUTE
                else if (word_mode) state_d = S_WORD;  // T_WORD
                else                state_d = S_BYTE;  // T_BYTE
            end
            default: state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/bwrp_read_port.sv
module bwrp_read_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic              word_mode_i,
    input  logic              dq15_in_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] dq_oe_o
);
    import bwrp_pkg::*;

    localparam logic [DATA_W-1:0] BYTE_OE = DATA_W'(8'hFF);

    logic [DATA_W-1:0] word_w, lanes_w, data_q;
    bwrp_state_e       state;

    bwrp_pattern_rom #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rom (
        .addr (addr_i),
        .word (word_w)
    );

    bwrp_lane_mux #(.DATA_W(DATA_W)) i_mux (
        .word_mode (word_mode_i),
        .hi_sel    (dq15_in_i),
        .word      (word_w),
        .lanes     (lanes_w)
    );

    bwrp_ctrl_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n_i),
        .oe_n      (oe_n_i),
        .word_mode (word_mode_i),
        .state     (state)
    );

    // Read data register: inputs ignored while deselected.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (!ce_n_i) data_q <= lanes_w;
    end

    // Output process driven from the state.
    always_comb begin
        unique case (state)
            S_WORD: begin
                dq_o    = data_q;
                dq_oe_o = '1;
            end
            S_BYTE: begin
                dq_o    = data_q & BYTE_OE;
                dq_oe_o = BYTE_OE;
            end
            S_OFF, S_MUTE: begin
                dq_o    = '0;
                dq_oe_o = '0;
            end
            default: begin
                dq_o    = '0;
                dq_oe_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/bwrp_read_port_chk.sv
module bwrp_read_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n_i,
    input logic              oe_n_i,
    input logic              word_mode_i,
    input logic [DATA_W-1:0] dq_o,
    input logic [DATA_W-1:0] dq_oe_o
);
    localparam int HALF = DATA_W / 2;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (dq_oe_o == '0 && dq_o == '0));

    assert_word_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n_i) && !$past(oe_n_i) && $past(word_mode_i))
        |-> dq_oe_o == '1);

    assert_byte_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n_i) && !$past(oe_n_i) && !$past(word_mode_i))
        |-> dq_oe_o == DATA_W'(8'hFF));

    assert_upper_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(word_mode_i)) |-> dq_oe_o[DATA_W-1:HALF] == '0);

    assert_deselect_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n_i)) |-> dq_oe_o == '0);

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ce_n_i) && $past(oe_n_i)) |-> dq_oe_o == '0);

    assert_no_undriven_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_o & ~dq_oe_o) == '0);

endmodule

bind bwrp_read_port bwrp_read_port_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n_i      (ce_n_i),
    .oe_n_i      (oe_n_i),
    .word_mode_i (word_mode_i),
    .dq_o        (dq_o),
    .dq_oe_o     (dq_oe_o)
);

// File: tb/test_bwrp_read_port.sv
`timescale 1ns/1ps
module test_bwrp_read_port;

    typedef struct {
        logic [15:0] dq;
        logic [15:0] oe;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic        ce_n_i = 1'b1;
    logic        oe_n_i = 1'b1;
    logic        word_mode_i = 1'b1;
    logic        dq15_in_i = 1'b0;
    logic [15:0] dq_o, dq_oe_o;

    int   errors = 0;
    int   checks = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    bwrp_read_port i_bwrp_read_port (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n_i(ce_n_i),
        .oe_n_i(oe_n_i), .word_mode_i(word_mode_i), .dq15_in_i(dq15_in_i),
        .dq_o(dq_o), .dq_oe_o(dq_oe_o)
    );

    function automatic logic [15:0] ref_word(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3CA5;   // R2
    endfunction

    task automatic compare(input logic [15:0] dq, input logic [15:0] oe, input string req);
        checks++;
        if (dq_o !== dq || dq_oe_o !== oe) begin
            errors++;
            $display("FAIL %s: dq=%h oe=%h expected dq=%h oe=%h", req, dq_o, dq_oe_o, dq, oe);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic ce, input logic oe,
                         input logic wm, input logic top, input string req);
        exp_t e;
        logic [15:0] w;
        @(negedge clk);
        addr_i = a; ce_n_i = ce; oe_n_i = oe; word_mode_i = wm; dq15_in_i = top;
        w = ref_word(a);
        if (ce || oe) begin
            e.dq = '0; e.oe = '0;
        end else if (wm) begin
            e.dq = w; e.oe = 16'hFFFF;
        end else begin
            e.dq = {8'h00, top ? w[15:8] : w[7:0]}; e.oe = 16'h00FF;
        end
        e.req = req;
        sb.push_back(e);
    endtask

    // monitor: one result per cycle, due one edge after the driver
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                compare(e.dq, e.oe, e.req);
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(16'h0000, 16'h0000, "R1 during reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        compare(16'h0000, 16'h0000, "R1 after reset");

        // word reads, several patterns (R2, R3)
        drive(16'h0000, 0, 0, 1, 0, "R3 word addr 0000");
        drive(16'h1234, 0, 0, 1, 0, "R2 word addr 1234");
        drive(16'hFFFF, 0, 0, 1, 1, "R3 word addr FFFF, top pin input ignored");
        drive(16'hA5C3, 0, 0, 1, 0, "R3 word addr A5C3");
        // byte reads (R4, R5, R6)
        drive(16'h1234, 0, 0, 0, 0, "R4 low byte 1234");
        drive(16'h1234, 0, 0, 0, 1, "R5 high byte 1234");
        drive(16'hFFFF, 0, 0, 0, 1, "R5 high byte FFFF");
        drive(16'hFFFF, 0, 0, 0, 0, "R4 low byte FFFF");
        drive(16'h8001, 0, 0, 0, 1, "R6 upper lanes off 8001");
        // deselect and output gating (R7, R8)
        drive(16'h5555, 1, 0, 1, 0, "R7 deselected word");
        drive(16'h5555, 1, 0, 0, 1, "R7 deselected byte");
        drive(16'h5555, 0, 1, 1, 0, "R8 output enable high word");
        drive(16'h5555, 0, 1, 0, 1, "R8 output enable high byte");
        drive(16'h5555, 0, 0, 1, 0, "R3 reselect word 5555");
        // mode switch on back-to-back cycles (R9)
        drive(16'h0F0F, 0, 0, 1, 0, "R9 word before switch");
        drive(16'h0F0F, 0, 0, 0, 0, "R9 low byte after switch");
        drive(16'h0F0F, 0, 0, 0, 1, "R9 high byte after switch");
        drive(16'h0F0F, 0, 0, 1, 1, "R9 word after switching back");
        drive(16'h0F0F, 1, 1, 1, 0, "R10 idle after test");
        for (int i = 0; i < 40; i++) begin
            drive(16'(i * 16'h0731), 0, 0, i[0], i[1], "R10 sweep");
        end
        @(posedge clk); #2;
        @(posedge clk); #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule